// File: doc/BRIEF.md
# USB Line State Encoder with Idle Reset Detection

This block produces the two-bit line state that a USB 2.0 device transceiver reports to its link controller. It takes the raw receiver outputs and builds the code from them. Those outputs are the single-ended DP and DM comparators, the squelch detector and the high-speed differential receiver. The transceiver-select and termination-select controls choose how the code is built. In full-speed operation the code mirrors the single-ended receivers. In high-speed and chirp operation the code comes from the squelch and differential outputs. High-speed activity is collapsed to J, so the code moves only between idle and J while the bus carries packets.

Every input is asynchronous to the local clock. Each one passes through a two-flop synchronizer, and the line state is then registered. The block also times continuous idle while in high-speed operation and raises a one-clock bus-reset pulse when the idle lasts long enough. The idle length is derived from a clock frequency parameter and a duration parameter in microseconds. The defaults are 60 MHz and 3000 us, which gives 180,000 cycles. After a pulse the detector stays quiet until the line leaves idle.

The idle detector is a three-state machine:
- WAIT holds the run count at zero. It moves to COUNT on the first qualifying idle cycle.
- COUNT advances on each qualifying cycle. It falls back to WAIT on any cycle that does not qualify. It moves to HOLD, and pulses, when the run reaches the limit.
- HOLD stays put while the line is idle. It returns to WAIT on the first non-idle line state.

Top module: `usb_linestate_rst`

## Requirements
- R1: Mode decode. `xcvr_sel_i`=1 selects full-speed, whatever the value of `term_sel_i`. `xcvr_sel_i`=0 with `term_sel_i`=0 selects high-speed. `xcvr_sel_i`=0 with `term_sel_i`=1 selects chirp.
- R2: The line state codes are 00 = SE0, 01 = J, 10 = K and 11 = SE1. In full-speed mode `linestate_o` = {dm, dp}, so bit 0 follows DP and bit 1 follows DM.
- R3: In high-speed mode `linestate_o` is 00 while squelch is 1 and 01 while squelch is 0. The differential receiver has no effect in this mode, and codes 10 and 11 never appear.
- R4: In chirp mode `linestate_o` is 00 while squelched. When not squelched it is 01 if `hs_rx_i`=1 and 10 if `hs_rx_i`=0. Code 11 never appears in this mode.
- R5: While squelch is 1 in high-speed or chirp mode, toggling `hs_rx_i` leaves `linestate_o` at 00.
- R6: A change on any input, mode controls included, appears on `linestate_o` after the third rising clock edge that follows it. Two of those edges are synchronizer stages and one is the output register.
- R7: While `rst_ni` is low, `linestate_o` is 00 and `bus_reset_o` is 0. The synchronizers reset to full-speed mode, squelched, with DP=DM=0.
- R8: A qualifying idle cycle is one where the registered mode is high-speed, `linestate_o` is 00, and the mode did not change on that cycle. After IDLE = (CLK_HZ/1e6)*IDLE_US consecutive qualifying cycles, `bus_reset_o` is 1 for exactly one clock. It rises on the edge after the last of those cycles.
- R9: The idle run restarts from zero on any cycle that does not qualify: a non-idle line state, a mode other than high-speed, or a mode change.
- R10: After a pulse, no further pulse occurs until `linestate_o` has shown a non-idle code. A fresh full idle run is then needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xcvr_sel_i | input | 1 | Transceiver select: 1 full-speed, 0 high-speed |
| term_sel_i | input | 1 | Termination select |
| dp_rx_i | input | 1 | Single-ended DP receiver output |
| dm_rx_i | input | 1 | Single-ended DM receiver output |
| squelch_i | input | 1 | Squelch detector, 1 = no high-speed activity |
| hs_rx_i | input | 1 | High-speed differential receiver output |
| linestate_o | output | 2 | Encoded line state |
| bus_reset_o | output | 1 | One-clock pulse on detected bus reset |

## Verification
Some properties are checked by assertions on every cycle:
- the code restrictions per mode;
- full-speed mirroring of DP and DM;
- squelch forcing idle;
- the single-cycle width of the pulse;
- the run count falling to zero on any cycle that does not qualify;
- HOLD being kept through idle.

Other behaviour shows only in the bench's scenarios, which compare the block against a behavioural model on every clock:
- the exact three-edge latency;
- the pulse landing on the right cycle after an uninterrupted run;
- the absence of a pulse when a run is broken one cycle short or by a mode change;
- re-arming after a non-idle code.

// File: rtl/usbls_pkg.sv
package usbls_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } lstate_e;

    typedef enum logic [1:0] {
        MODE_FS    = 2'b00,
        MODE_HS    = 2'b01,
        MODE_CHIRP = 2'b10
    } xmode_e;

    typedef struct packed {
        logic xcvr;
        logic term;
        logic dp;
        logic dm;
        logic squelch;
        logic hs_rx;
    } rx_bundle_t;

    localparam int RX_W = $bits(rx_bundle_t);

    // full-speed, squelched, both single-ended lines low
    localparam logic [RX_W-1:0] RX_RESET_VAL = 6'b110010;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/usbls_sync.sv
module usbls_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[0] <= RST_VAL;
                    else         stage_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[s] <= RST_VAL;
                    else         stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/usbls_encoder.sv
module usbls_encoder
    import usbls_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  rx_bundle_t rx_i,
    output lstate_e    ls_o,
    output xmode_e     mode_o
);

    xmode_e  mode_c;
    lstate_e ls_c;
    xmode_e  mode_q;
    lstate_e ls_q;

    always_comb begin
        if (rx_i.xcvr)      mode_c = MODE_FS;
        else if (rx_i.term) mode_c = MODE_CHIRP;
        else                mode_c = MODE_HS;
    end

    always_comb begin
        ls_c = LS_SE0;
        unique case (mode_c)
            MODE_FS: begin
                ls_c = lstate_e'({rx_i.dm, rx_i.dp});
            end
            MODE_HS: begin
                ls_c = rx_i.squelch ? LS_SE0 : LS_J;
            end
            MODE_CHIRP: begin
                if (rx_i.squelch)    ls_c = LS_SE0;
                else if (rx_i.hs_rx) ls_c = LS_J;
                else                 ls_c = LS_K;
            end
            default: ls_c = LS_SE0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ls_q   <= LS_SE0;
            mode_q <= MODE_FS;
        end else begin
            ls_q   <= ls_c;
            mode_q <= mode_c;
        end
    end

    assign ls_o   = ls_q;
    assign mode_o = mode_q;

    AST_HS_J_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_HS) |-> (ls_q == LS_SE0 || ls_q == LS_J)); // R3

    AST_CHIRP_NO_SE1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q == MODE_CHIRP) |-> (ls_q != LS_SE1)); // R4

    AST_SQUELCH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rx_i.xcvr && rx_i.squelch) |=> (ls_q == LS_SE0)); // R5

    AST_FS_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_i.xcvr |=> (ls_q == lstate_e'({$past(rx_i.dm), $past(rx_i.dp)}))); // R2

endmodule

// File: rtl/usbls_idle_fsm.sv
module usbls_idle_fsm
    import usbls_pkg::*;
#(
    parameter int LIMIT = 180000
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  lstate_e ls_i,
    input  xmode_e  mode_i,
    output logic    pulse_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LIMIT - 1);

    typedef enum logic [1:0] {
        IF_WAIT  = 2'b00,
        IF_COUNT = 2'b01,
        IF_HOLD  = 2'b10
    } idle_st_e;

    idle_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pulse_q, pulse_d;
    xmode_e           mode_d1_q;
    logic             qualify;
    logic             at_last;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mode_d1_q <= MODE_FS;
        else         mode_d1_q <= mode_i;
    end

    assign qualify = (mode_i == MODE_HS) && (ls_i == LS_SE0) && (mode_i == mode_d1_q);
    assign at_last = (cnt_q == LAST_CNT);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= IF_WAIT;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IF_WAIT:  if (qualify) state_d = IF_COUNT;
            IF_COUNT: begin
                if (!qualify)    state_d = IF_WAIT;
                else if (at_last) state_d = IF_HOLD;
            end
            IF_HOLD:  if (ls_i != LS_SE0) state_d = IF_WAIT;
            default:  state_d = IF_WAIT;
        endcase
    end

    // outputs and run counter
    always_comb begin
        cnt_d   = '0;
        pulse_d = 1'b0;
        unique case (state_q)
            IF_WAIT:  cnt_d = qualify ? CNT_W'(1) : '0;
            IF_COUNT: begin
                if (qualify && !at_last) cnt_d = cnt_q + CNT_W'(1);
                pulse_d = qualify && at_last;
            end
            IF_HOLD:  cnt_d = '0;
            default:  cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            pulse_q <= pulse_d;
        end
    end

    assign pulse_o = pulse_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_q |=> !pulse_q); // R8

    AST_PULSE_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_q |-> ($past(ls_i) == LS_SE0 && $past(mode_i) == MODE_HS)); // R8

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < CNT_W'(LIMIT)); // R8

    AST_RUN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !qualify |=> (cnt_q == '0)); // R9

    AST_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == IF_HOLD && ls_i == LS_SE0) |=> (state_q == IF_HOLD && !pulse_q)); // R10

endmodule

// File: rtl/usb_linestate_rst.sv
module usb_linestate_rst
    import usbls_pkg::*;
#(
    parameter int CLK_HZ  = 60_000_000,
    parameter int IDLE_US = 3000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       xcvr_sel_i,
    input  logic       term_sel_i,
    input  logic       dp_rx_i,
    input  logic       dm_rx_i,
    input  logic       squelch_i,
    input  logic       hs_rx_i,
    output logic [1:0] linestate_o,
    output logic       bus_reset_o
);

    localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
    localparam int IDLE_CYCLES = CYC_PER_US * IDLE_US;

    rx_bundle_t     rx_raw;
    logic [RX_W-1:0] rx_sync_vec;
    rx_bundle_t     rx_sync;
    lstate_e        ls;
    xmode_e         mode;

    always_comb begin
        rx_raw.xcvr    = xcvr_sel_i;
        rx_raw.term    = term_sel_i;
        rx_raw.dp      = dp_rx_i;
        rx_raw.dm      = dm_rx_i;
        rx_raw.squelch = squelch_i;
        rx_raw.hs_rx   = hs_rx_i;
    end

    usbls_sync #(
        .WIDTH   (RX_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (RX_RESET_VAL)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rx_raw),
        .q_o    (rx_sync_vec)
    );

    assign rx_sync = rx_bundle_t'(rx_sync_vec);

    usbls_encoder u_enc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rx_i   (rx_sync),
        .ls_o   (ls),
        .mode_o (mode)
    );

    usbls_idle_fsm #(
        .LIMIT (IDLE_CYCLES)
    ) u_idle (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ls_i    (ls),
        .mode_i  (mode),
        .pulse_o (bus_reset_o)
    );

    assign linestate_o = ls;

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |-> (linestate_o == 2'b00 && !bus_reset_o)); // R7

endmodule

// File: tb/usb_linestate_rst_bench.sv
`timescale 1ns/1ps
module usb_linestate_rst_bench;

    localparam int CLK_HZ  = 4_000_000;
    localparam int IDLE_US = 5;
    localparam int LIMIT   = (CLK_HZ / 1_000_000) * IDLE_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xcvr = 1'b1, term = 1'b1, dp = 1'b0, dm = 1'b0, sq = 1'b1, hsrx = 1'b0;
    logic [1:0] linestate;
    logic       bus_reset;

    always #2 clk = ~clk;

    usb_linestate_rst #(.CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US)) u_usb_linestate_rst (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .xcvr_sel_i  (xcvr),
        .term_sel_i  (term),
        .dp_rx_i     (dp),
        .dm_rx_i     (dm),
        .squelch_i   (sq),
        .hs_rx_i     (hsrx),
        .linestate_o (linestate),
        .bus_reset_o (bus_reset)
    );

    int    checks = 0;
    int    fails = 0;
    int    pulses = 0;
    int    cycles = 0;
    string cur_req = "R7";

    // behavioural reference: mode 0 = FS, 1 = HS, 2 = chirp
    function automatic int mode_of(logic x, logic t);
        if (x) return 0;
        return t ? 2 : 1;
    endfunction

    function automatic logic [1:0] code_of(logic x, logic t, logic p, logic m, logic s, logic h);
        int md = mode_of(x, t);
        if (md == 0) return {m, p};
        if (s) return 2'b00;
        if (md == 1) return 2'b01;
        return h ? 2'b01 : 2'b10;
    endfunction

    logic [1:0] qc[2];
    int         qm[2];
    logic [1:0] m_ls;
    int         m_mode, m_mode_d1, run;
    bit         latched, m_pulse;

    always @(posedge clk) begin
        if (!rst_n) begin
            qc[0] = 2'b00; qc[1] = 2'b00; qm[0] = 0; qm[1] = 0;
            m_ls = 2'b00; m_mode = 0; m_mode_d1 = 0;
            run = 0; latched = 0; m_pulse = 0;
        end else begin
            bit cond;
            cond = (m_mode == 1) && (m_ls == 2'b00) && (m_mode == m_mode_d1);
            m_pulse = 0;
            if (latched) begin
                if (m_ls != 2'b00) begin latched = 0; run = 0; end
            end else if (cond) begin
                run++;
                if (run == LIMIT) begin m_pulse = 1; latched = 1; run = 0; end
            end else begin
                run = 0;
            end
            m_mode_d1 = m_mode;
            m_ls   = qc[1];
            m_mode = qm[1];
            qc[1] = qc[0];
            qm[1] = qm[0];
            qc[0] = code_of(xcvr, term, dp, dm, sq, hsrx);
            qm[0] = mode_of(xcvr, term);
        end
    end

    task automatic chk(string req, int actual, int expected, string what);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, actual, expected, cycles);
        end
    endtask

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, int'(linestate), int'(m_ls), "linestate");
            chk("R8", int'(bus_reset), int'(m_pulse), "bus_reset");
            if (bus_reset) pulses++;
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            report();
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(logic x, logic t);
        xcvr = x; term = t;
    endtask

    initial begin
        int p0;
        step(3);
        // R7: reset state
        chk("R7", int'(linestate), 0, "linestate in reset");
        chk("R7", int'(bus_reset), 0, "bus_reset in reset");
        rst_n = 1'b1;
        step(4);
        chk("R7", int'(linestate), 0, "linestate after reset");

        // R2 and R1: full-speed mirroring, both termination settings
        cur_req = "R2";
        for (int t = 0; t < 2; t++) begin
            set_mode(1'b1, t[0]);
            for (int v = 0; v < 4; v++) begin
                dp = v[0]; dm = v[1];
                step(4);
                chk(t == 0 ? "R1" : "R2", int'(linestate), v, "full-speed code");
            end
        end

        // R6: three-edge latency
        cur_req = "R6";
        set_mode(1'b1, 1'b1); dp = 1'b0; dm = 1'b0;
        step(5);
        dp = 1'b1;
        step(1); chk("R6", int'(linestate), 0, "edge 1");
        step(1); chk("R6", int'(linestate), 0, "edge 2");
        step(1); chk("R6", int'(linestate), 1, "edge 3");
        dp = 1'b0;

        // R3: high-speed, differential receiver ignored
        cur_req = "R3";
        set_mode(1'b0, 1'b0); sq = 1'b0;
        step(4);
        for (int i = 0; i < 8; i++) begin
            hsrx = i[0];
            step(1);
            chk("R3", int'(linestate), 1, "high-speed active J");
        end
        sq = 1'b1;
        step(4);
        chk("R3", int'(linestate), 0, "high-speed squelched");

        // R4 and R5: chirp mode
        cur_req = "R4";
        set_mode(1'b0, 1'b1); sq = 1'b0; hsrx = 1'b1;
        step(4); chk("R4", int'(linestate), 1, "chirp J");
        hsrx = 1'b0;
        step(4); chk("R4", int'(linestate), 2, "chirp K");
        cur_req = "R5";
        sq = 1'b1;
        step(3);
        for (int i = 0; i < 6; i++) begin
            hsrx = ~hsrx;
            step(1);
            chk("R5", int'(linestate), 0, "squelch masks hs_rx");
        end

        // R8: a full idle run in high-speed gives one pulse
        cur_req = "R8";
        set_mode(1'b0, 1'b0); sq = 1'b0;
        step(4);
        p0 = pulses;
        sq = 1'b1;
        step(LIMIT + 8);
        chk("R8", pulses - p0, 1, "pulse count after one idle run");

        // R10: stays quiet while idle continues, rearms after activity
        cur_req = "R10";
        p0 = pulses;
        step(3 * LIMIT);
        chk("R10", pulses - p0, 0, "no refire during continued idle");
        sq = 1'b0; step(2); sq = 1'b1;
        step(LIMIT + 8);
        chk("R10", pulses - p0, 1, "pulse after rearm");

        // R9: broken runs never pulse
        cur_req = "R9";
        sq = 1'b0; step(4);
        p0 = pulses;
        sq = 1'b1; step(LIMIT - 2);
        sq = 1'b0; step(1);
        sq = 1'b1; step(LIMIT - 2);
        sq = 1'b0; step(4);
        chk("R9", pulses - p0, 0, "run broken by activity");
        p0 = pulses;
        sq = 1'b1; step(LIMIT - 4);
        set_mode(1'b0, 1'b1); step(3);
        set_mode(1'b0, 1'b0); step(LIMIT - 6);
        chk("R9", pulses - p0, 0, "run broken by mode change");
        step(12);
        chk("R9", pulses - p0, 1, "fresh run after mode change");

        // mixed random traffic, model compared every cycle
        cur_req = "R1";
        for (int i = 0; i < 3000; i++) begin
            if (i % 60 == 0) set_mode(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 7) == 0) sq = ~sq;
            hsrx = 1'($urandom_range(0, 1));
            dp   = 1'($urandom_range(0, 1));
            dm   = 1'($urandom_range(0, 1));
            step(1);
        end
        step(5);
        report();
    end

endmodule